// File: doc/BRIEF.md
# Pole-Count Tachometer Pulse Divider

This block converts commutation timing of a brushless motor into a tachometer square wave whose rate is chosen so that the output yields two pulses per mechanical revolution, whatever the pole count of the motor. The commutation logic supplies a single-cycle strobe at every half electrical cycle together with a level that says the motor is being driven. The block counts those strobes and shapes a registered, glitch-free tachometer level from them. It also emits a one-clock strobe on every rising edge of that level, for the speed-measurement logic that times successive rising edges.

A 2-bit pole selector picks one of four divide patterns. Three of them are plain square waves at one, one half and one third of the electrical rate. The fourth gives two pulses every three electrical cycles and is deliberately not 50% duty. A new selector value is taken only at a rising edge of the output, so a change never produces a runt pulse. Dropping the run level forces the output low and restarts the pattern.

Top module: `fg_pole_div`

## Requirements
- R1: After a synchronous active-low reset, fgOut and fgRise are 0 and the active selection is code 00.
- R2: With selection 00 (4-pole), fgOut toggles on every half-cycle strobe, so it gives one pulse per electrical cycle: high for 1 strobe, then low for 1 strobe.
- R3: With selection 10 (8-pole), fgOut is high for 2 strobes and then low for 2 strobes, repeating.
- R4: With selection 11 (12-pole), fgOut is high for 3 strobes and then low for 3 strobes, repeating.
- R5: With selection 01 (6-pole), fgOut repeats a 3-strobe period: high for 2 strobes, then low for 1 strobe (non-50% duty).
- R6: fgRise is high for exactly one clock, in the same cycle that fgOut first reads 1 after reading 0. It is never high otherwise, including when strobes arrive on consecutive clocks.
- R7: A change of poleCfg takes effect only at the next rising edge of fgOut. The current pattern finishes under the old selection, and the new pattern starts from its first high strobe at that edge.
- R8: While runEn is 0, fgOut and fgRise are 0 from the next clock on and strobes are ignored. The first strobe after runEn returns to 1 starts a high phase and raises fgRise.
- R9: fgOut changes only on the clock edge that samples a strobe (or a stop). Without strobes it holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| runEn | input | 1 | Motor driven; 0 forces the output low and restarts the pattern |
| halfStrobe | input | 1 | One-cycle pulse at every half electrical cycle |
| poleCfg | input | 2 | Pole selector: 00 4-pole, 01 6-pole, 10 8-pole, 11 12-pole |
| fgOut | output | 1 | Registered tachometer level |
| fgRise | output | 1 | One-clock pulse on each rising edge of fgOut |

## Verification
The bench walks each selector code through more than one full period starting from a stop. A design with wrong high or low lengths, or one that starts its pattern in the low phase, shows a mismatched level at the first differing strobe. A selector change is made in the middle of a pulse. A design that switches at once would shorten the pulse or start the new pattern at the wrong point, where a correct one finishes the old period first. Strobes on consecutive clocks catch a rising-edge pulse that is stretched or missed. Strobes sent while stopped, and a stop in the middle of a high phase, catch designs that keep counting while stopped or leave the output high.

// File: rtl/fg_div_pkg.sv
package fg_div_pkg;

  localparam int SelW = 2;
  localparam int PosW = 3;

  typedef enum logic [SelW-1:0] {
    POLE4  = 2'b00,
    POLE6  = 2'b01,
    POLE8  = 2'b10,
    POLE12 = 2'b11
  } poleSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;    // stopped: force low, reset position
    logic restart;  // strobe at position zero: rising edge
    logic step;     // strobe elsewhere in the period
  } fgCtrl_t;

  // shape of one period, counted in half-cycle strobes
  typedef struct packed {
    logic [PosW-1:0] lastPos;
    logic [PosW-1:0] highLen;
  } fgShape_t;

  function automatic fgShape_t shapeOf(poleSel_e sel);
    fgShape_t s;
    case (sel)
      POLE4:   begin s.lastPos = PosW'(1); s.highLen = PosW'(1); end
      POLE6:   begin s.lastPos = PosW'(2); s.highLen = PosW'(2); end
      POLE8:   begin s.lastPos = PosW'(3); s.highLen = PosW'(2); end
      default: begin s.lastPos = PosW'(5); s.highLen = PosW'(3); end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/fg_div_ctrl.sv
module fg_div_ctrl
  import fg_div_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            runEn,
  input  logic            halfStrobe,
  input  logic [SelW-1:0] poleCfg,
  input  logic            phaseZero,
  output fgCtrl_t         ctrl,
  output fgShape_t        shape
);

  poleSel_e activeSel;

  always_comb begin
    ctrl.clear   = !runEn;
    ctrl.restart = runEn && halfStrobe && phaseZero;
    ctrl.step    = runEn && halfStrobe && !phaseZero;
  end

  // the selection is adopted only when a new pulse begins
  always_ff @(posedge clk) begin
    if (!rstN)
      activeSel <= POLE4;
    else if (ctrl.restart)
      activeSel <= poleSel_e'(poleCfg);
  end

  assign shape = shapeOf(activeSel);

endmodule

// File: rtl/fg_div_dp.sv
module fg_div_dp
  import fg_div_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  fgCtrl_t  ctrl,
  input  fgShape_t shape,
  output logic     phaseZero,
  output logic     fgOut,
  output logic     fgRise
);

  logic [PosW-1:0] pos;

  assign phaseZero = (pos == '0);

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clear) begin
      pos    <= '0;
      fgOut  <= 1'b0;
      fgRise <= 1'b0;
    end else if (ctrl.restart) begin
      pos    <= PosW'(1);
      fgOut  <= 1'b1;
      fgRise <= 1'b1;
    end else if (ctrl.step) begin
      fgOut  <= (pos < shape.highLen);
      pos    <= (pos == shape.lastPos) ? '0 : PosW'(pos + 1'b1);
      fgRise <= 1'b0;
    end else begin
      fgRise <= 1'b0;
    end
  end

endmodule

// File: rtl/fg_pole_div.sv
module fg_pole_div
  import fg_div_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            runEn,
  input  logic            halfStrobe,
  input  logic [SelW-1:0] poleCfg,
  output logic            fgOut,
  output logic            fgRise
);

  fgCtrl_t  ctrl;
  fgShape_t shape;
  logic     phaseZero;

  fg_div_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .runEn      (runEn),
    .halfStrobe (halfStrobe),
    .poleCfg    (poleCfg),
    .phaseZero  (phaseZero),
    .ctrl       (ctrl),
    .shape      (shape)
  );

  fg_div_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .shape     (shape),
    .phaseZero (phaseZero),
    .fgOut     (fgOut),
    .fgRise    (fgRise)
  );

endmodule

// File: rtl/fg_pole_div_chk.sv
module fg_pole_div_chk (
  input logic clk,
  input logic rstN,
  input logic runEn,
  input logic halfStrobe,
  input logic fgOut,
  input logic fgRise
);

  // R6: the pulse marks a low-to-high change of the level
  a_r6_rise_marks_edge: assert property (@(posedge clk) disable iff (!rstN)
    fgRise |-> (fgOut && !$past(fgOut)));

  // R6: every low-to-high change is marked
  a_r6_edge_has_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fgOut) |-> fgRise);

  // R9: without a strobe while running, the level holds
  a_r9_hold_without_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && !halfStrobe) |=> $stable(fgOut));

  // R8: stopping forces both outputs low
  a_r8_stop_forces_low: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (!fgOut && !fgRise));

  // R8: a rising edge needs a strobe while running
  a_r8_rise_needs_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (!halfStrobe || !runEn) |=> !fgRise);

endmodule

bind fg_pole_div fg_pole_div_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .runEn      (runEn),
  .halfStrobe (halfStrobe),
  .fgOut      (fgOut),
  .fgRise     (fgRise)
);

// File: tb/fg_pole_div_tb.sv
module fg_pole_div_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 1'b0;
  logic halfStrobe = 1'b0;
  logic [1:0] poleCfg = 2'b00;
  logic fgOut;
  logic fgRise;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;
  logic prevFg = 1'b0;

  always #5 clk = ~clk;

  fg_pole_div u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .runEn      (runEn),
    .halfStrobe (halfStrobe),
    .poleCfg    (poleCfg),
    .fgOut      (fgOut),
    .fgRise     (fgRise)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic act, input logic exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  // one strobe, then check level and edge pulse, then check pulse is gone
  task automatic strobeCheck(input logic expFg, input string req);
    logic expRise;
    expRise = expFg && !prevFg;
    @(negedge clk) halfStrobe = 1'b1;
    @(negedge clk) halfStrobe = 1'b0;
    check(fgOut === expFg, req, "fgOut", fgOut, expFg);
    check(fgRise === expRise, req, "fgRise", fgRise, expRise);
    @(negedge clk);
    check(fgRise === 1'b0, "R6", "fgRise one clock", fgRise, 1'b0);
    prevFg = expFg;
  endtask

  task automatic stopAndSelect(input logic [1:0] sel);
    @(negedge clk) runEn = 1'b0;
    poleCfg = sel;
    repeat (2) @(negedge clk);
    runEn = 1'b1;
    prevFg = 1'b0;
  endtask

  task automatic runPattern(input logic [1:0] sel, input logic [15:0] pat,
                            input int n, input string req);
    stopAndSelect(sel);
    for (int i = 0; i < n; i++)
      strobeCheck(pat[n-1-i], req);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(fgOut === 1'b0, "R1", "fgOut in reset", fgOut, 1'b0);
    check(fgRise === 1'b0, "R1", "fgRise in reset", fgRise, 1'b0);
    rstN = 1'b1;
    runEn = 1'b1;
    poleCfg = 2'b00;
    prevFg = 1'b0;
    // R1: default selection 00 gives toggling on each strobe
    strobeCheck(1'b1, "R1");
    strobeCheck(1'b0, "R1");
  endtask

  task automatic testHold();
    stopAndSelect(2'b10);
    strobeCheck(1'b1, "R3");
    repeat (5) @(negedge clk);
    check(fgOut === 1'b1, "R9", "fgOut held", fgOut, 1'b1);
    check(fgRise === 1'b0, "R9", "fgRise idle", fgRise, 1'b0);
  endtask

  task automatic testBackToBack();
    stopAndSelect(2'b00);
    @(negedge clk) halfStrobe = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(fgOut === ((i % 2) == 0), "R6", "fgOut back-to-back", fgOut, (i % 2) == 0);
      check(fgRise === ((i % 2) == 0), "R6", "fgRise back-to-back", fgRise, (i % 2) == 0);
    end
    halfStrobe = 1'b0;
    @(negedge clk);
    prevFg = fgOut;
  endtask

  task automatic testCfgChange();
    stopAndSelect(2'b00);
    strobeCheck(1'b1, "R7");
    poleCfg = 2'b11;
    strobeCheck(1'b0, "R7");
    strobeCheck(1'b1, "R7");
    strobeCheck(1'b1, "R7");
    strobeCheck(1'b1, "R7");
    strobeCheck(1'b0, "R7");
    strobeCheck(1'b0, "R7");
    strobeCheck(1'b0, "R7");
    strobeCheck(1'b1, "R7");
  endtask

  task automatic testStop();
    stopAndSelect(2'b01);
    strobeCheck(1'b1, "R8");
    @(negedge clk) runEn = 1'b0;
    @(negedge clk);
    check(fgOut === 1'b0, "R8", "fgOut after stop", fgOut, 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk) halfStrobe = 1'b1;
      @(negedge clk) halfStrobe = 1'b0;
      check(fgOut === 1'b0, "R8", "fgOut stopped", fgOut, 1'b0);
      check(fgRise === 1'b0, "R8", "fgRise stopped", fgRise, 1'b0);
    end
    runEn = 1'b1;
    prevFg = 1'b0;
    strobeCheck(1'b1, "R8");
    strobeCheck(1'b1, "R8");
    strobeCheck(1'b0, "R8");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    testReset();
    runPattern(2'b00, 16'b1010, 4, "R2");
    runPattern(2'b10, 16'b11001100, 8, "R3");
    runPattern(2'b11, 16'b111000111000, 12, "R4");
    runPattern(2'b01, 16'b110110110, 9, "R5");
    testBackToBack();
    testHold();
    testCfgChange();
    testStop();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule